// File: doc/BRIEF.md
# Single-Wire Debug Bit Transmitter

This block is the target-side engine that returns one data bit to a debug host over a single open-drain line. The host opens every bit time by pulling the line low. The target finishes the bit. It either leaves the line to the pull-up, which gives a one, or keeps it low for a fixed time, which gives a zero. In both cases it closes with a one-cycle active-high pulse that speeds up the rising edge. Surrounding logic handles framing and command decoding. It loads one bit at a time with a strobe, then waits for `done` before it loads the next bit.

The pin input passes through a two-flop synchroniser. A start is the synchronised high-to-low transition, and it is accepted only while the block is armed. The controller has seven named states:

- `ST_IDLE`: waits for a load.
- `ST_ARMED`: waits for the host edge.
- `ST_WAIT_HI`: counts up to the speed-up pulse for a one.
- `ST_HOLD_LO`: drives the line low for a zero.
- `ST_KICK`: drives the speed-up pulse.
- `ST_RELEASE`: waits until the synchronised line reads high.
- `ST_DONE`: the one-cycle completion state.

The transitions are:

- IDLE to ARMED on load.
- DONE to ARMED on load.
- DONE to IDLE when no load arrives.
- ARMED to WAIT_HI on a start edge with bit 1.
- ARMED to HOLD_LO on a start edge with bit 0.
- WAIT_HI to KICK when the timer expires.
- HOLD_LO to KICK when the timer expires.
- KICK to RELEASE unconditionally.
- RELEASE to DONE when the synchronised line is high.

Top module: `dbg_bit_tx`

## Requirements
- R1: After reset, `drv_en`, `busy` and `done` are all 0.
- R2: A `load` pulse while `busy` is 0 captures `load_bit` and sets `busy` to 1 from the next cycle.
- R3: The perceived start of a bit is the third rising clock edge after the pin goes low: two synchroniser flops, then the edge detect. A falling edge while the block is not armed causes no drive and leaves `busy` at 0.
- R4: For bit value 1, the block never drives the line low. It drives `drv_en`=1 and `drv_val`=1 for exactly one cycle, beginning 7 cycles after the perceived start.
- R5: For bit value 0, the block drives `drv_en`=1 and `drv_val`=0 for 13 cycles beginning at the perceived start. It then drives `drv_val`=1 for one cycle.
- R6: After the speed-up pulse `drv_en` returns to 0, and `drv_en` is never 1 while `busy` is 0.
- R7: After the pulse, the block ignores the pin until the synchronised line reads high. It then raises `done` for one cycle, in the same cycle that `busy` falls.
- R8: A `load` pulse while `busy` is 1 is ignored. The bit in progress keeps its timing and value.
- R9: Ten cycles after the host's falling edge, the line reads 0 when a zero is sent and 1 when a one is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Strobe that arms the block with a new bit |
| load_bit | input | 1 | Data bit captured on `load` |
| pin_in | input | 1 | Level read back from the shared line |
| drv_en | output | 1 | Output enable of the pin driver |
| drv_val | output | 1 | Value driven when `drv_en` is 1 |
| busy | output | 1 | High from arming until completion |
| done | output | 1 | One-cycle pulse when the bit is finished |

## Verification
The bench drives a host model through the resistive line. It randomises the host's low time, the gap before the falling edge, and the data bit, and it injects a stray `load` in the middle of a bit.

It targets the following corner cases, each with the failure it would expose:
- **Off-by-one counters:** a design with an off-by-one count shifts the speed-up pulse or shortens the zero hold, and the host would then sample the wrong level.
- **Missing release wait:** a design without the release wait would finish before its own pulse had settled.
- **Arming check:** a design that does not gate edges by arming would start driving on a host edge it was never asked to answer.
- **Loads during a bit:** a design that re-captures the bit during a transfer would change the value in flight.

// File: rtl/dbg_bit_tx_pkg.sv
package dbg_bit_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_WAIT_HI,
        ST_HOLD_LO,
        ST_KICK,
        ST_RELEASE,
        ST_DONE
    } tx_state_e;

endpackage

// File: rtl/dbg_line_sync.sv
module dbg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dbg_bit_timer.sv
module dbg_bit_timer #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [WIDTH-1:0] limit,
    output logic             hit
);
    logic [WIDTH-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= cnt + 1'b1;
    end

    assign hit = en && (cnt == limit);

    // timer never runs past its programmed limit while counting
    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= limit)); // R5
endmodule

// File: rtl/dbg_bit_tx.sv
module dbg_bit_tx
    import dbg_bit_tx_pkg::*;
#(
    parameter int ONE_DELAY   = 7,
    parameter int LOW_CYCLES  = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_bit,
    input  logic pin_in,
    output logic drv_en,
    output logic drv_val,
    output logic busy,
    output logic done
);
    localparam int MAX_CNT = (ONE_DELAY > LOW_CYCLES) ? ONE_DELAY : LOW_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] ONE_LIM  = CNT_W'(ONE_DELAY - 1);
    localparam logic [CNT_W-1:0] ZERO_LIM = CNT_W'(LOW_CYCLES - 1);

    tx_state_e        state, state_nx;
    logic             bit_q;
    logic             line_s, line_prev;
    logic             start_edge;
    logic             tmr_clr, tmr_en, tmr_hit;
    logic [CNT_W-1:0] tmr_lim;

    dbg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (line_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_prev <= 1'b1;
        else        line_prev <= line_s;
    end

    assign start_edge = (state == ST_ARMED) && line_prev && !line_s;

    assign tmr_lim = bit_q ? ONE_LIM : ZERO_LIM;
    assign tmr_clr = (state == ST_ARMED);
    assign tmr_en  = (state == ST_WAIT_HI) || (state == ST_HOLD_LO);

    dbg_bit_timer #(.WIDTH(CNT_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .en   (tmr_en),
        .limit(tmr_lim),
        .hit  (tmr_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else if (load && (state == ST_IDLE || state == ST_DONE)) bit_q <= load_bit;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (load) state_nx = ST_ARMED;
            ST_ARMED:   if (start_edge) state_nx = bit_q ? ST_WAIT_HI : ST_HOLD_LO;
            ST_WAIT_HI: if (tmr_hit) state_nx = ST_KICK;
            ST_HOLD_LO: if (tmr_hit) state_nx = ST_KICK;
            ST_KICK:    state_nx = ST_RELEASE;
            ST_RELEASE: if (line_s) state_nx = ST_DONE;
            ST_DONE:    state_nx = load ? ST_ARMED : ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        drv_en  = 1'b0;
        drv_val = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_ARMED:   busy = 1'b1;
            ST_WAIT_HI: busy = 1'b1;
            ST_HOLD_LO: begin busy = 1'b1; drv_en = 1'b1; end
            ST_KICK:    begin busy = 1'b1; drv_en = 1'b1; drv_val = 1'b1; end
            ST_RELEASE: busy = 1'b1;
            ST_DONE:    done = 1'b1;
            default:    ;
        endcase
    end

    AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && drv_val) |=> !drv_en); // R6
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !drv_en); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load) |=> $stable(bit_q)); // R8
    AST_ONE_NEVER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && bit_q) |-> drv_val); // R4
    AST_ZERO_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && drv_val && !bit_q) |-> $past(drv_en && !drv_val)); // R5
endmodule

// File: tb/tb_dbg_bit_tx.sv
module tb_dbg_bit_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0;
    logic load_bit = 1'b0;
    logic host_low = 1'b0;
    logic pin;
    logic drv_en, drv_val, busy, done;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    assign pin = drv_en ? drv_val : !host_low;

    dbg_bit_tx dut (
        .clk(clk), .rst_n(rst_n), .load(load), .load_bit(load_bit),
        .pin_in(pin), .drv_en(drv_en), .drv_val(drv_val),
        .busy(busy), .done(done)
    );

    // expected outputs, k = negedges after the host edge
    function automatic logic [3:0] expect_out(input logic b, input int k);
        logic en, val, bz, dn;
        if (b) begin
            en = (k == 10); val = (k == 10); dn = (k == 12); bz = (k < 12);
        end else begin
            en = (k >= 3 && k <= 16); val = (k == 16); dn = (k == 19); bz = (k < 19);
        end
        return {en, val, bz, dn};
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic run_bit(input logic b, input int hold, input int gap, input bit stray);
        logic [3:0] e;
        load = 1'b1; load_bit = b;
        @(negedge clk);
        load = 1'b0;
        check("R2", "busy after load", busy, 1'b1);
        repeat (gap) @(negedge clk);
        host_low = 1'b1;
        for (int k = 1; k <= 22; k++) begin
            @(negedge clk);
            e = expect_out(b, k);
            check(b ? "R4" : "R5", "drv_en", drv_en, e[3]);
            if (e[3]) check(b ? "R4" : "R5", "drv_val", drv_val, e[2]);
            check(stray ? "R8" : "R7", "busy", busy, e[1]);
            check("R7", "done", done, e[0]);
            if (k == 10) check("R9", "line at host sample", pin, b);
            if (k >= 17) check("R6", "released", drv_en, 1'b0);
            if (k == 3) check("R3", "perceived start", drv_en, !b);
            if (k == hold) host_low = 1'b0;
            if (stray && k == 5) begin load = 1'b1; load_bit = !b; end
            else load = 1'b0;
        end
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(1234);
        #1;
        check("R1", "drv_en reset", drv_en, 1'b0);
        check("R1", "busy reset", busy, 1'b0);
        check("R1", "done reset", done, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", busy, 1'b0);

        // R3: host edge while not armed is ignored
        host_low = 1'b1;
        repeat (3) @(negedge clk);
        host_low = 1'b0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            check("R3", "no drive when idle", drv_en, 1'b0);
            check("R3", "idle busy", busy, 1'b0);
        end

        // directed corners
        run_bit(1'b0, 2, 1, 1'b0);
        run_bit(1'b1, 6, 3, 1'b0);
        run_bit(1'b0, 6, 2, 1'b1);   // R8 stray load during zero
        run_bit(1'b1, 2, 1, 1'b1);   // R8 stray load during one

        // constrained random
        for (int i = 0; i < 40; i++) begin
            logic rb;
            int   rh, rg;
            bit   rs;
            rb = 1'($urandom_range(0, 1));
            rh = int'($urandom_range(2, 6));
            rg = int'($urandom_range(1, 5));
            rs = ($urandom_range(0, 3) == 0);
            run_bit(rb, rh, rg, rs);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule